// File: doc/BRIEF.md
# Multi-Level Radix Table Walker

This block turns an effective address into a real address by following a tree of page directories held in memory. A request supplies the effective address, the base address of the root directory, the index width of the root directory and the total number of address bits the tree covers. The walker fetches one 64-bit entry per level through a simple read port: a request held until accepted, then one returned data beat. Each directory entry names the base and the index width of the next level, so a tree may mix directory sizes. A leaf may sit at any level, and the address bits not yet consumed at that point set the page size.

A walk ends in one of four ways. A leaf gives a translation. An entry without its valid bit gives a missing-entry fault. An index width that cannot be used gives a configuration fault. Running past the deepest allowed level gives a depth fault. The result is shown for one cycle together with a done pulse. Permission checks and filling any translation cache belong to the blocks that use this one.

Top module: `rw_walker`

## Requirements
- R1: After reset, busy, mem_req and done are low and fault_cause is zero.
- R2: An index width below 5, whether it comes from the request or from a directory entry, ends the walk with fault_cause = 3'b001 (configuration) and no memory read for that level.
- R3: Each read address equals the level base plus 8 times the index. The index is effective-address bits [rem-1 : rem-nls], where rem is the number of address bits not yet consumed and nls is the level's index width. Effective-address bits at or above the request size never affect the walk.
- R4: An entry with bit 63 clear ends the walk with fault_cause = 3'b010 (missing entry), whatever its other bits hold.
- R5: An entry with bits 63 and 62 both set is a leaf. Then real_addr takes entry bits [PA_W-1:12] above bit page_size and the effective address below it. page_size is the remaining bit count after this level, which may be zero. leaf_entry is the whole entry, entry_addr is its address and fault_cause is zero.
- R6: An entry with bit 63 set and bit 62 clear is a directory. The next base is entry bits [PA_W-1:8] with eight low zero bits, the next index width is entry bits [4:0], and the remaining bit count drops by the current level's index width.
- R7: A directory fetched at level MAX_LEVELS (default 5) ends the walk with fault_cause = 3'b100 (depth). A leaf at that level is still accepted.
- R8: An index width larger than the remaining bit count ends the walk with fault_cause = 3'b001 and no read for that level.
- R9: busy is high from the cycle after a request is taken up to and including the done cycle. req_valid has no effect while busy is high.
- R10: Once raised, mem_req stays high with an unchanged mem_addr until a cycle with mem_ready high.
- R11: done lasts exactly one cycle and at most one fault_cause bit is set. On a fault, real_addr, leaf_entry, entry_addr and page_size are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start a walk, taken only when idle |
| req_ea | input | 64 | Effective address to translate |
| req_base | input | PA_W | Root directory base address |
| req_nls | input | 5 | Root directory index width |
| req_size | input | 6 | Total address bits covered by the tree |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | PA_W | Address of the entry being read |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Entry read from memory |
| done | output | 1 | One-cycle end-of-walk pulse |
| fault_cause | output | 3 | bit0 configuration, bit1 missing entry, bit2 depth |
| real_addr | output | PA_W | Translated address |
| leaf_entry | output | 64 | Leaf entry that ended the walk |
| entry_addr | output | PA_W | Address of the leaf entry |
| page_size | output | 6 | log2 of the page size |

## Verification
The bench targets the edges of the bit bookkeeping. It uses a leaf at the root, a leaf that leaves zero offset bits, and a root whose index width equals the whole size, where the shift is zero. A walker that got the subtraction or the mask wrong would read from the wrong slot or merge the wrong number of low address bits. Index widths of 4 and widths larger than the remaining bits are placed at the root and at deeper levels, so a walker that checked only the request, or checked after reading, would issue a stray read. A fifth-level directory and a fifth-level leaf sit side by side to catch a depth counter off by one. A request arriving mid-walk, together with a memory that stalls and answers late, shows whether busy guards the captured request and whether the read request holds its address.

// File: rtl/rw_pkg.sv
// Shared constants and types for the radix table walker.
// Assumes 64-bit entries and effective addresses.
package rw_pkg;
    localparam int EA_W    = 64;
    localparam int ENT_W   = 64;
    localparam int NLS_W   = 5;
    localparam int SIZE_W  = NLS_W + 1;
    localparam int MIN_NLS = 5;
    localparam int BIT_VALID = 63;
    localparam int BIT_LEAF  = 62;
    localparam int NB_LO   = 8;   // lowest bit of the next-level base field
    localparam int RPN_LO  = 12;  // lowest bit of the leaf frame field
    localparam int FLT_W   = 3;
    localparam int FLT_CFG   = 0;
    localparam int FLT_NOENT = 1;
    localparam int FLT_DEPTH = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } walk_state_e;
endpackage

// File: rtl/rw_index_gen.sv
// Level index and entry address generation.
// Computes the index from the effective address and the remaining bit
// count, and flags an index width that is too small or too large.
// Assumes nls <= rem whenever cfg_bad is low.
module rw_index_gen
    import rw_pkg::*;
#(
    parameter int PA_W = 56
) (
    input  logic [EA_W-1:0]   ea,
    input  logic [PA_W-1:0]   base,
    input  logic [NLS_W-1:0]  nls,
    input  logic [SIZE_W-1:0] rem,
    output logic              cfg_bad,
    output logic [PA_W-1:0]   entry_addr
);
    logic [SIZE_W-1:0] shift;
    logic [EA_W-1:0]   shifted;
    logic [EA_W-1:0]   idx_mask;
    logic [EA_W-1:0]   idx;

    // Index extraction, width check and slot address.
    always_comb begin
        cfg_bad    = (nls < NLS_W'(MIN_NLS)) || (SIZE_W'(nls) > rem);
        shift      = rem - SIZE_W'(nls);
        shifted    = ea >> shift;
        idx_mask   = (EA_W'(1) << nls) - EA_W'(1);
        idx        = shifted & idx_mask;
        entry_addr = base + PA_W'(idx << 3);
    end
endmodule

// File: rtl/rw_entry_decode.sv
// Splits a fetched entry into its control bits and next-level fields.
// Assumes PA_W <= 61 so the base field stays below the flag bits.
module rw_entry_decode
    import rw_pkg::*;
#(
    parameter int PA_W = 56
) (
    input  logic [ENT_W-1:0] entry,
    output logic             ent_valid,
    output logic             ent_leaf,
    output logic [PA_W-1:0]  next_base,
    output logic [NLS_W-1:0] next_nls
);
    logic unused_bits;

    // Field extraction.
    always_comb begin
        ent_valid   = entry[BIT_VALID];
        ent_leaf    = entry[BIT_LEAF];
        next_base   = {entry[PA_W-1:NB_LO], {NB_LO{1'b0}}};
        next_nls    = entry[NLS_W-1:0];
        unused_bits = ^{entry[ENT_W-3:PA_W], entry[NB_LO-1:NLS_W]};
    end
endmodule

// File: rtl/rw_leaf_join.sv
// Forms the real address from a leaf frame field and the page offset
// taken from the effective address.
// Assumes page_bits < 64.
module rw_leaf_join
    import rw_pkg::*;
#(
    parameter int PA_W = 56
) (
    input  logic [PA_W-1-RPN_LO:0] frame,
    input  logic [EA_W-1:0]        ea,
    input  logic [SIZE_W-1:0]      page_bits,
    output logic [PA_W-1:0]        real_addr
);
    logic [EA_W-1:0] off_mask;
    logic [EA_W-1:0] rpn;
    logic [EA_W-1:0] joined;

    // Merge frame bits above the page offset with offset bits below it.
    always_comb begin
        off_mask  = (EA_W'(1) << page_bits) - EA_W'(1);
        rpn       = EA_W'({frame, {RPN_LO{1'b0}}});
        joined    = (rpn & ~off_mask) | (ea & off_mask);
        real_addr = joined[PA_W-1:0];
    end
endmodule

// File: rtl/rw_walker.sv
// Radix table walker top. One entry read per level, ends on a leaf,
// an invalid entry, an unusable index width or excess depth.
// Assumes the memory answers each accepted read with exactly one
// mem_rvalid beat, never before the cycle after acceptance.
module rw_walker
    import rw_pkg::*;
#(
    parameter int PA_W       = 56,
    parameter int MAX_LEVELS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [EA_W-1:0]   req_ea,
    input  logic [PA_W-1:0]   req_base,
    input  logic [NLS_W-1:0]  req_nls,
    input  logic [SIZE_W-1:0] req_size,
    output logic              busy,
    output logic              mem_req,
    output logic [PA_W-1:0]   mem_addr,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    input  logic [ENT_W-1:0]  mem_rdata,
    output logic              done,
    output logic [FLT_W-1:0]  fault_cause,
    output logic [PA_W-1:0]   real_addr,
    output logic [ENT_W-1:0]  leaf_entry,
    output logic [PA_W-1:0]   entry_addr,
    output logic [SIZE_W-1:0] page_size
);
    localparam int LVL_W = $clog2(MAX_LEVELS + 1);

    walk_state_e       state;
    logic [EA_W-1:0]   ea_q;
    logic [PA_W-1:0]   base_q;
    logic [NLS_W-1:0]  nls_q;
    logic [SIZE_W-1:0] rem_q;
    logic [LVL_W-1:0]  lvl_q;
    logic [PA_W-1:0]   addr_q;
    logic [FLT_W-1:0]  flt_q;
    logic [PA_W-1:0]   ra_q;
    logic [ENT_W-1:0]  leaf_q;
    logic [PA_W-1:0]   eaddr_q;
    logic [SIZE_W-1:0] psize_q;

    logic              cfg_bad;
    logic [PA_W-1:0]   slot_addr;
    logic              ent_valid;
    logic              ent_leaf;
    logic [PA_W-1:0]   nxt_base;
    logic [NLS_W-1:0]  nxt_nls;
    logic [SIZE_W-1:0] rem_after;
    logic [PA_W-1:0]   join_ra;

    rw_index_gen #(.PA_W(PA_W)) u_index (
        .ea         (ea_q),
        .base       (base_q),
        .nls        (nls_q),
        .rem        (rem_q),
        .cfg_bad    (cfg_bad),
        .entry_addr (slot_addr)
    );

    rw_entry_decode #(.PA_W(PA_W)) u_decode (
        .entry     (mem_rdata),
        .ent_valid (ent_valid),
        .ent_leaf  (ent_leaf),
        .next_base (nxt_base),
        .next_nls  (nxt_nls)
    );

    rw_leaf_join #(.PA_W(PA_W)) u_join (
        .frame     (mem_rdata[PA_W-1:RPN_LO]),
        .ea        (ea_q),
        .page_bits (rem_after),
        .real_addr (join_ra)
    );

    // Bits left once the current level's index is consumed.
    always_comb rem_after = rem_q - SIZE_W'(nls_q);

    // Walk sequencing and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            ea_q    <= '0;
            base_q  <= '0;
            nls_q   <= '0;
            rem_q   <= '0;
            lvl_q   <= '0;
            addr_q  <= '0;
            flt_q   <= '0;
            ra_q    <= '0;
            leaf_q  <= '0;
            eaddr_q <= '0;
            psize_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        ea_q    <= req_ea;
                        base_q  <= req_base;
                        nls_q   <= req_nls;
                        rem_q   <= req_size;
                        lvl_q   <= LVL_W'(1);
                        flt_q   <= '0;
                        ra_q    <= '0;
                        leaf_q  <= '0;
                        eaddr_q <= '0;
                        psize_q <= '0;
                        state   <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (cfg_bad) begin
                        flt_q[FLT_CFG] <= 1'b1;
                        state          <= ST_DONE;
                    end else begin
                        addr_q <= slot_addr;
                        state  <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (mem_ready) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rvalid) begin
                        if (!ent_valid) begin
                            flt_q[FLT_NOENT] <= 1'b1;
                            state            <= ST_DONE;
                        end else if (ent_leaf) begin
                            ra_q    <= join_ra;
                            leaf_q  <= mem_rdata;
                            eaddr_q <= addr_q;
                            psize_q <= rem_after;
                            state   <= ST_DONE;
                        end else if (lvl_q == LVL_W'(MAX_LEVELS)) begin
                            flt_q[FLT_DEPTH] <= 1'b1;
                            state            <= ST_DONE;
                        end else begin
                            base_q <= nxt_base;
                            nls_q  <= nxt_nls;
                            rem_q  <= rem_after;
                            lvl_q  <= lvl_q + LVL_W'(1);
                            state  <= ST_CHECK;
                        end
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Port drive from state and captured results.
    always_comb begin
        busy        = (state != ST_IDLE);
        mem_req     = (state == ST_ISSUE);
        mem_addr    = addr_q;
        done        = (state == ST_DONE);
        fault_cause = flt_q;
        real_addr   = ra_q;
        leaf_entry  = leaf_q;
        entry_addr  = eaddr_q;
        page_size   = psize_q;
    end
endmodule

// File: rtl/rw_walker_chk.sv
// Protocol and result checks for rw_walker, attached by bind.
// Observes ports only.
module rw_walker_chk
    import rw_pkg::*;
#(
    parameter int PA_W = 56
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [NLS_W-1:0]  req_nls,
    input logic              busy,
    input logic              mem_req,
    input logic [PA_W-1:0]   mem_addr,
    input logic              mem_ready,
    input logic              done,
    input logic [FLT_W-1:0]  fault_cause,
    input logic [PA_W-1:0]   real_addr,
    input logic [ENT_W-1:0]  leaf_entry,
    input logic [PA_W-1:0]   entry_addr,
    input logic [SIZE_W-1:0] page_size
);
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !done));

    assert_busy_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_fault_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $onehot0(fault_cause));

    assert_fault_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault_cause != '0) |->
            (real_addr == '0 && leaf_entry == '0 && entry_addr == '0 && page_size == '0));

    assert_leaf_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault_cause == '0) |-> (leaf_entry[BIT_VALID] && leaf_entry[BIT_LEAF]));

    assert_small_root_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_nls < NLS_W'(MIN_NLS)) |=>
            (!mem_req ##1 (done && fault_cause == 3'b001)));
endmodule

bind rw_walker rw_walker_chk #(.PA_W(PA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_nls     (req_nls),
    .busy        (busy),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_ready   (mem_ready),
    .done        (done),
    .fault_cause (fault_cause),
    .real_addr   (real_addr),
    .leaf_entry  (leaf_entry),
    .entry_addr  (entry_addr),
    .page_size   (page_size)
);

// File: tb/rw_walker_tb.sv
`timescale 1ns/1ps
// Bench for rw_walker: behavioural tree model, memory responder with
// stalls and latency, checks on every handshake and on every result.
module rw_walker_tb;
    localparam int PA_W = 56;
    localparam int MAXL = 5;

    typedef struct {
        logic [2:0]  flt;
        logic [55:0] ra;
        logic [63:0] ent;
        logic [55:0] ea_addr;
        logic [5:0]  ps;
    } res_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        req_valid = 1'b0;
    logic [63:0] req_ea = '0;
    logic [55:0] req_base = '0;
    logic [4:0]  req_nls = '0;
    logic [5:0]  req_size = '0;
    logic        busy, mem_req, done;
    logic [55:0] mem_addr, real_addr, entry_addr;
    logic        mem_ready, mem_rvalid;
    logic [63:0] mem_rdata, leaf_entry;
    logic [2:0]  fault_cause;
    logic [5:0]  page_size;

    rw_walker #(.PA_W(PA_W), .MAX_LEVELS(MAXL)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(req_ea),
        .req_base(req_base), .req_nls(req_nls), .req_size(req_size),
        .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .done(done), .fault_cause(fault_cause), .real_addr(real_addr),
        .leaf_entry(leaf_entry), .entry_addr(entry_addr), .page_size(page_size)
    );

    logic [63:0] mem [logic [55:0]];
    logic [55:0] exp_addr [$];
    int n_cmp = 0;
    int n_bad = 0;
    int lat = 1;
    int rmode = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] dir_e(input logic [55:0] b, input logic [4:0] n);
        return 64'h8000_0000_0000_0000 | {8'h0, b & 56'hFF_FFFF_FFFF_FF00} | {59'h0, n};
    endfunction

    function automatic logic [63:0] leaf_e(input logic [55:0] pa, input logic [11:0] attr);
        return 64'hC000_0000_0000_0000 | {8'h0, pa & 56'hFF_FFFF_FFFF_F000} | {52'h0, attr};
    endfunction

    function automatic logic [55:0] slot(input logic [55:0] b, input logic [63:0] ea,
                                         input int rem, input int nls);
        logic [63:0] ix;
        ix = (ea >> (rem - nls)) & ((64'd1 << nls) - 64'd1);
        return b + 56'(ix * 64'd8);
    endfunction

    // Behavioural walk over the bench memory; fills exp_addr.
    function automatic res_t model(input logic [63:0] ea, input logic [55:0] base_in,
                                   input int nls_in, input int size);
        res_t r;
        int rem;
        int nls;
        logic [55:0] b;
        r = '{flt: 3'b0, ra: 56'h0, ent: 64'h0, ea_addr: 56'h0, ps: 6'h0};
        rem = size;
        nls = nls_in;
        b = base_in;
        exp_addr.delete();
        for (int lvl = 1; lvl <= MAXL; lvl++) begin
            logic [55:0] a;
            logic [63:0] e;
            logic [63:0] m;
            logic [63:0] full;
            if (nls < 5 || nls > rem) begin r.flt = 3'b001; return r; end
            a = slot(b, ea, rem, nls);
            exp_addr.push_back(a);
            e = mem.exists(a) ? mem[a] : 64'h0;
            if (!e[63]) begin r.flt = 3'b010; return r; end
            rem = rem - nls;
            if (e[62]) begin
                m = (64'd1 << rem) - 64'd1;
                full = ((e & 64'h00FF_FFFF_FFFF_F000) & ~m) | (ea & m);
                r.ra = full[55:0];
                r.ent = e;
                r.ea_addr = a;
                r.ps = 6'(rem);
                return r;
            end
            if (lvl == MAXL) begin r.flt = 3'b100; return r; end
            b = {e[55:8], 8'h0};
            nls = int'(e[4:0]);
        end
        return r;
    endfunction

    // Memory responder: decides ready, checks holds and read addresses, returns data.
    initial begin
        int cnt;
        int cyc;
        bit stall_prev;
        logic [55:0] stall_addr;
        logic [55:0] pend;
        logic [55:0] a;
        cnt = 0; cyc = 0; stall_prev = 0; stall_addr = '0; pend = '0;
        mem_ready = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
        forever begin
            @(negedge clk);
            cyc++;
            mem_rvalid = 1'b0;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata = mem.exists(pend) ? mem[pend] : 64'h0;
                end
            end
            mem_ready = (rmode == 0) ? 1'b1 : ((cyc % 3) == 0);
            if (stall_prev)
                check(mem_req && mem_addr == stall_addr, "R10 request held",
                      {7'h0, mem_req, mem_addr}, {8'h01, stall_addr});
            stall_prev = mem_req && !mem_ready;
            stall_addr = mem_addr;
            if (mem_req && mem_ready) begin
                if (exp_addr.size() == 0) begin
                    check(0, "R3 unexpected read", {8'h0, mem_addr}, 64'h0);
                end else begin
                    a = exp_addr.pop_front();
                    check(mem_addr == a, "R3 entry address", {8'h0, mem_addr}, {8'h0, a});
                end
                pend = mem_addr;
                cnt = lat;
            end
        end
    end

    // Global watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic walk(input string tag, input logic [63:0] ea, input logic [55:0] base,
                        input logic [4:0] nls, input logic [5:0] size, input bit intrude);
        res_t e;
        int t;
        e = model(ea, base, int'(nls), int'(size));
        @(negedge clk);
        req_valid = 1'b1; req_ea = ea; req_base = base; req_nls = nls; req_size = size;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, {tag, " R9 busy after accept"}, {63'h0, busy}, 64'h1);
        if (intrude) begin
            req_valid = 1'b1; req_ea = ~ea; req_base = base + 56'h1000;
            req_nls = 5'd7; req_size = 6'd40;
            repeat (3) begin
                @(negedge clk);
                check(busy == 1'b1 && done == 1'b0, {tag, " R9 still walking"},
                      {62'h0, busy, done}, 64'h2);
            end
            req_valid = 1'b0;
        end
        t = 0;
        while (!done && t < 400) begin
            @(negedge clk);
            t++;
        end
        if (!done) begin
            check(0, {tag, " watchdog no done"}, 64'h0, 64'h1);
            return;
        end
        check(fault_cause == e.flt, {tag, " fault_cause"}, {61'h0, fault_cause}, {61'h0, e.flt});
        check(real_addr == e.ra, {tag, " real_addr"}, {8'h0, real_addr}, {8'h0, e.ra});
        check(leaf_entry == e.ent, {tag, " leaf_entry"}, leaf_entry, e.ent);
        check(entry_addr == e.ea_addr, {tag, " entry_addr"}, {8'h0, entry_addr}, {8'h0, e.ea_addr});
        check(page_size == e.ps, {tag, " page_size"}, {58'h0, page_size}, {58'h0, e.ps});
        check(busy == 1'b1, {tag, " R9 busy in done cycle"}, {63'h0, busy}, 64'h1);
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, {tag, " R11 done single pulse"},
              {62'h0, busy, done}, 64'h0);
        check(exp_addr.size() == 0, {tag, " R3 all reads issued"},
              64'(exp_addr.size()), 64'h0);
    endtask

    initial begin
        logic [63:0] ea;
        logic [55:0] a;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && mem_req == 0 && done == 0 && fault_cause == 0, "R1 reset state",
              {60'h0, busy, mem_req, done, |fault_cause}, 64'h0);

        // R2: root index width below 5, no read.
        mem.delete();
        walk("R2 small root", 64'h1234_5678_9ABC_DEF0, 56'h1000, 5'd3, 6'd52, 0);
        // R8: root index width above size.
        walk("R8 root too wide", 64'hFF, 56'h1000, 5'd9, 6'd8, 0);

        // R5 R6 R3: three levels to a 2^21 page, high EA bits set.
        mem.delete();
        ea = 64'hC000_0ABC_DE12_3456;
        mem[slot(56'h10_0000, ea, 52, 13)] = dir_e(56'h20_0000, 5'd9);
        mem[slot(56'h20_0000, ea, 39, 9)]  = dir_e(56'h30_0000, 5'd9);
        mem[slot(56'h30_0000, ea, 30, 9)]  = leaf_e(56'hAB_CDE0_0000, 12'h5A3);
        walk("R5 R6 three-level leaf", ea, 56'h10_0000, 5'd13, 6'd52, 0);
        // R9: same walk with a competing request while busy.
        walk("R9 ignore while busy", ea, 56'h10_0000, 5'd13, 6'd52, 1);

        // R10: four levels to a 2^12 page with stalls and latency.
        mem.delete();
        ea = 64'h0000_F123_4567_89AB;
        mem[slot(56'h10_0000, ea, 52, 13)] = dir_e(56'h21_0000, 5'd9);
        mem[slot(56'h21_0000, ea, 39, 9)]  = dir_e(56'h32_0000, 5'd9);
        mem[slot(56'h32_0000, ea, 30, 9)]  = dir_e(56'h43_0000, 5'd9);
        mem[slot(56'h43_0000, ea, 21, 9)]  = leaf_e(56'h12_3456_7000, 12'h0FF);
        rmode = 1; lat = 4;
        walk("R10 R6 stalled four-level", ea, 56'h10_0000, 5'd13, 6'd52, 0);
        rmode = 0; lat = 1;

        // R5: leaf at the root level.
        mem.delete();
        ea = 64'h0007_89AB_CDEF_0123;
        mem[slot(56'h50_0000, ea, 52, 13)] = leaf_e(56'hF0_0000_0000_0000, 12'h001);
        walk("R5 root leaf", ea, 56'h50_0000, 5'd13, 6'd52, 0);

        // R4: missing entry at level 2; entry with leaf bit but no valid bit at root.
        mem.delete();
        ea = 64'h0001_1111_2222_3333;
        mem[slot(56'h60_0000, ea, 52, 13)] = dir_e(56'h61_0000, 5'd9);
        walk("R4 invalid level 2", ea, 56'h60_0000, 5'd13, 6'd52, 0);
        a = slot(56'h60_0000, ea, 52, 13);
        mem[a] = 64'h4000_0000_ABCD_E000;
        walk("R4 leaf without valid", ea, 56'h60_0000, 5'd13, 6'd52, 0);

        // R2: directory names index width 4 at level 2.
        mem[a] = dir_e(56'h61_0000, 5'd4);
        walk("R2 small inner width", ea, 56'h60_0000, 5'd13, 6'd52, 0);

        // R8: inner width larger than remaining bits.
        mem.delete();
        ea = 64'h0000_0000_0000_0ABC;
        mem[slot(56'h70_0000, ea, 12, 5)] = dir_e(56'h71_0000, 5'd8);
        walk("R8 inner too wide", ea, 56'h70_0000, 5'd5, 6'd12, 0);

        // R7: five directories exceed the depth limit.
        mem.delete();
        ea = 64'h000A_5A5A_5A5A_5A5A;
        for (int k = 0; k < 5; k++)
            mem[slot(56'h80_0000 + 56'(k * 32'h1_0000), ea, 52 - 5 * k, 5)] =
                dir_e(56'h80_0000 + 56'((k + 1) * 32'h1_0000), 5'd5);
        walk("R7 depth exceeded", ea, 56'h80_0000, 5'd5, 6'd52, 0);
        // R7: leaf at the last permitted level.
        mem[slot(56'h84_0000, ea, 32, 5)] = leaf_e(56'h33_4444_5000, 12'h123);
        walk("R7 leaf at last level", ea, 56'h80_0000, 5'd5, 6'd52, 0);

        // R5: zero page bits left.
        mem.delete();
        ea = 64'h0000_0000_000F_FFFF;
        mem[slot(56'h90_0000, ea, 20, 10)] = dir_e(56'h91_0000, 5'd10);
        mem[slot(56'h91_0000, ea, 10, 10)] = leaf_e(56'h55_6666_7000, 12'hABC);
        walk("R5 zero page bits", ea, 56'h90_0000, 5'd10, 6'd20, 0);

        // R3: root width equals the whole size, shift of zero.
        mem.delete();
        ea = 64'hFFFF_FFFF_FFFF_E123;
        mem[slot(56'hA0_0000, ea, 13, 13)] = leaf_e(56'h77_8888_9000, 12'h010);
        walk("R3 zero shift", ea, 56'hA0_0000, 5'd13, 6'd13, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule